// File: doc/BRIEF.md
# Identification and Query Read Responder

This block sits on the read path of a parallel NOR-style flash controller and answers reads while the device is in one of its identification modes. It watches the write strobes that reach the device and tracks four modes: normal read, autoselect (manufacturer and device identification), query (self-description table) entered from normal read, and query entered from autoselect. Entry into autoselect is signalled by the command sequencer through a one-cycle pulse. Entry into either query mode is decoded here from a single command write.

Each read request is decoded against the current mode. The result is one of three things: an identification word, a byte of the self-description table, or a flag telling the surrounding logic to return ordinary array contents. The table holds a signature, the command-set code, the extended-table pointer, the two erase timing exponents, the device size and one descriptor per erase region. It is computed at elaboration from parameters.

Read requests use a valid/ready handshake and responses come back one cycle later on a registered valid/ready channel. A request is accepted only when the response register is empty or is being drained in the same cycle. A response that is not taken stays unchanged until `rsp_ready` is high. Writes and the autoselect pulse are plain strobes with no back-pressure.

Top module: `qry_responder`

## Requirements
- R1: After reset `mode` is 0 (normal read), `rsp_valid` is 0 and `rd_ready` is 1. The `mode` encoding is: 0 normal read, 1 autoselect, 2 query from read, 3 query from autoselect.
- R2: In mode 0, a write of 0x98 whose word address has low 11 bits equal to 0x055 moves to mode 2 on the next cycle. The word address is the byte address shifted right by log2(WIDTH_BYTES). Any other write leaves mode 0 unchanged.
- R3: In mode 1, a write of 0x98 at word address 0x055 moves to mode 3.
- R4: In mode 3, a write of 0xF0 returns to mode 1, and any other write goes to mode 0.
- R5: In mode 2, any write returns to mode 0.
- R6: In mode 1, any write other than the query entry of R3 goes to mode 0. An `autosel_enter` pulse with no write in the same cycle moves mode 0 to mode 1. The pulse is ignored in every other mode, and a write in the same cycle takes precedence.
- R7: In mode 1, the read offset is the low 8 bits of the byte address shifted right by log2(WIDTH_BYTES). Offset 0 returns ID0, offset 1 returns ID1 and offset 2 returns 0, each with `rsp_array` = 0.
- R8: In mode 1, offsets 0x0E and 0x0F return ID2 and ID3. If the low byte of that ID is 0xFF, the response instead has `rsp_array` = 1 and data 0. Every other offset also gives `rsp_array` = 1 and data 0.
- R9: In modes 2 and 3, the response is the table byte at the offset, zero-extended, with `rsp_array` = 0. The table has these entries: 0x10..0x12 = 0x51, 0x52, 0x59; 0x13 = 0x02; 0x15 = 0x40; 0x21 = block-erase exponent; 0x22 = chip-erase exponent; 0x27 = ceil(log2(total bytes)); 0x2C = region count; 0x40..0x44 = 0x50, 0x52, 0x49, 0x31, 0x30. All other entries below 0x4D are 0, and offsets 0x4D and above read 0.
- R10: Region k (k < region count, at most 4) occupies table entries 0x2D+4k..0x30+4k. These hold blocks−1 (low byte, then high byte) followed by sector bytes/256 (low byte, then high byte). Descriptor slots past the region count read 0.
- R11: In mode 0, every response has `rsp_array` = 1 and data 0.
- R12: A response is produced one cycle after a read is accepted and reflects the mode in the accepting cycle. `rd_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response data and flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A device write occurs this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Command byte of the write |
| autosel_enter | input | 1 | Pulse from the sequencer: autoselect command completed |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 8*WIDTH_BYTES | Identification word or table byte |
| rsp_array | output | 1 | Array data must be returned instead of rsp_data |
| mode | output | 2 | Current mode, encoded as in R1 |

## Verification
The bench builds the block with a 16-bit bus (WIDTH_BYTES = 2) and two erase regions: 8 blocks of 8 KiB and 15 blocks of 64 KiB. This gives a 1 MiB device, so the size entry is 20. It also exercises a nonzero high byte in a sector-size field, and leaves two descriptor slots that must read 0. ID2 is 0x2201 and ID3 is 0x22FF, so one identification slot answers while the other falls back to array data. With the byte-to-word shift in place, both byte addresses 0xAA and 0xAB hit the query-entry address, and offsets run up to 0x7F, past the table end.

// File: rtl/qry_pkg.sv
package qry_pkg;
  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_QRY     = 2'd2,
    MODE_QRY_AS  = 2'd3
  } qmode_e;

  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam int TBL_LEN     = 77;
  localparam int MAX_REGIONS = 4;
endpackage

// File: rtl/qry_mode_fsm.sv
module qry_mode_fsm
  import qry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_hit,
  input  logic [7:0] wr_data,
  input  logic       autosel_enter,
  output qmode_e     mode_q
);
  qmode_e mode_d;
  logic   qry_cmd;

  assign qry_cmd = wr_hit && (wr_data == CMD_QUERY);

  always_comb begin
    mode_d = mode_q;
    if (wr_valid) begin
      unique case (mode_q)
        MODE_READ:    if (qry_cmd) mode_d = MODE_QRY;
        MODE_AUTOSEL: mode_d = qry_cmd ? MODE_QRY_AS : MODE_READ;
        MODE_QRY:     mode_d = MODE_READ;
        MODE_QRY_AS:  mode_d = (wr_data == CMD_RESET) ? MODE_AUTOSEL : MODE_READ;
        default:      mode_d = MODE_READ;
      endcase
    end else if (autosel_enter && mode_q == MODE_READ) begin
      mode_d = MODE_AUTOSEL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_READ;
    else        mode_q <= mode_d;
  end

  assert_qry_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && wr_valid && wr_hit && wr_data == CMD_QUERY) |=> (mode_q == MODE_QRY));

  assert_as_qry_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_AUTOSEL && wr_valid && wr_hit && wr_data == CMD_QUERY) |=> (mode_q == MODE_QRY_AS));

  assert_back_to_as_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_QRY_AS && wr_valid && wr_data == CMD_RESET) |=> (mode_q == MODE_AUTOSEL));

  assert_qry_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_QRY && wr_valid) |=> (mode_q == MODE_READ));

  assert_pulse_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_READ && !wr_valid) |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/qry_table_rom.sv
module qry_table_rom
  import qry_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int unsigned REGION_BLOCKS [MAX_REGIONS] = '{8, 15, 0, 0},
  parameter int unsigned REGION_SECTOR [MAX_REGIONS] = '{32'h2000, 32'h10000, 0, 0},
  parameter logic [7:0] BLK_ERASE_EXP  = 8'h09,
  parameter logic [7:0] CHIP_ERASE_EXP = 8'h0C
) (
  input  logic [7:0] idx,
  output logic [7:0] byte_q
);
  localparam int REGION_BASE = 'h2D;

  function automatic logic [7:0] size_log2();
    longint unsigned total = 0;
    for (int i = 0; i < MAX_REGIONS; i++)
      if (i < NUM_REGIONS)
        total += longint'(REGION_BLOCKS[i]) * longint'(REGION_SECTOR[i]);
    return 8'($clog2(total));
  endfunction

  function automatic logic [7:0] entry(int a);
    int r;
    int f;
    logic [31:0] cnt;
    logic [31:0] units;
    case (a)
      'h10: return 8'h51;
      'h11: return 8'h52;
      'h12: return 8'h59;
      'h13: return 8'h02;
      'h15: return 8'h40;
      'h21: return BLK_ERASE_EXP;
      'h22: return CHIP_ERASE_EXP;
      'h27: return size_log2();
      'h2C: return 8'(NUM_REGIONS);
      'h40: return 8'h50;
      'h41: return 8'h52;
      'h42: return 8'h49;
      'h43: return 8'h31;
      'h44: return 8'h30;
      default: begin
        if (a >= REGION_BASE && a < REGION_BASE + 4 * NUM_REGIONS) begin
          r     = (a - REGION_BASE) / 4;
          f     = (a - REGION_BASE) % 4;
          cnt   = REGION_BLOCKS[r] - 1;
          units = REGION_SECTOR[r] >> 8;
          case (f)
            0:       return cnt[7:0];
            1:       return cnt[15:8];
            2:       return units[7:0];
            default: return units[15:8];
          endcase
        end
        return 8'h00;
      end
    endcase
  endfunction

  logic [7:0] rom [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_rom
    localparam logic [7:0] VAL = entry(g);
    assign rom[g] = VAL;
  end

  always_comb begin
    byte_q = 8'h00;
    for (int i = 0; i < TBL_LEN; i++)
      if (idx == 8'(i)) byte_q = rom[i];
  end

  assert_past_end_R9: assert property (@(idx) (int'(idx) >= TBL_LEN) |-> (byte_q == 8'h00));
endmodule

// File: rtl/qry_read_decode.sv
module qry_read_decode
  import qry_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2201,
  parameter logic [15:0] ID3 = 16'h22FF
) (
  input  qmode_e            mode,
  input  logic [7:0]        off,
  input  logic [7:0]        tbl_byte,
  output logic [DATA_W-1:0] data,
  output logic              use_array
);
  always_comb begin
    data      = '0;
    use_array = 1'b0;
    unique case (mode)
      MODE_READ: use_array = 1'b1;
      MODE_AUTOSEL: begin
        unique case (off)
          8'h00: data = DATA_W'(ID0);
          8'h01: data = DATA_W'(ID1);
          8'h02: data = '0;
          8'h0E: if (ID2[7:0] == 8'hFF) use_array = 1'b1; else data = DATA_W'(ID2);
          8'h0F: if (ID3[7:0] == 8'hFF) use_array = 1'b1; else data = DATA_W'(ID3);
          default: use_array = 1'b1;
        endcase
      end
      default: data = DATA_W'(tbl_byte);
    endcase
  end
endmodule

// File: rtl/qry_responder.sv
module qry_responder
  import qry_pkg::*;
#(
  parameter int WIDTH_BYTES = 2,
  parameter int ADDR_W      = 20,
  parameter int NUM_REGIONS = 2,
  parameter int unsigned REGION_BLOCKS [MAX_REGIONS] = '{8, 15, 0, 0},
  parameter int unsigned REGION_SECTOR [MAX_REGIONS] = '{32'h2000, 32'h10000, 0, 0},
  parameter logic [7:0]  BLK_ERASE_EXP  = 8'h09,
  parameter logic [7:0]  CHIP_ERASE_EXP = 8'h0C,
  parameter logic [10:0] QRY_WORD_ADDR  = 11'h055,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2201,
  parameter logic [15:0] ID3 = 16'h22FF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     autosel_enter,
  input  logic                     rd_valid,
  output logic                     rd_ready,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [8*WIDTH_BYTES-1:0] rsp_data,
  output logic                     rsp_array,
  output logic [1:0]               mode
);
  localparam int DATA_W = 8 * WIDTH_BYTES;
  localparam int SHIFT  = $clog2(WIDTH_BYTES);

  qmode_e            mode_q;
  logic              wr_hit;
  logic [7:0]        off;
  logic [7:0]        tbl_byte;
  logic [DATA_W-1:0] dec_data;
  logic              dec_array;
  logic              accept;

  assign wr_hit = (((wr_addr >> SHIFT) & ADDR_W'(11'h7FF)) == ADDR_W'(QRY_WORD_ADDR));
  assign off    = 8'((rd_addr & ADDR_W'(8'hFF)) >> SHIFT);

  qry_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_hit(wr_hit),
    .wr_data(wr_data), .autosel_enter(autosel_enter), .mode_q(mode_q)
  );

  qry_table_rom #(
    .NUM_REGIONS(NUM_REGIONS), .REGION_BLOCKS(REGION_BLOCKS), .REGION_SECTOR(REGION_SECTOR),
    .BLK_ERASE_EXP(BLK_ERASE_EXP), .CHIP_ERASE_EXP(CHIP_ERASE_EXP)
  ) u_rom (
    .idx(off), .byte_q(tbl_byte)
  );

  qry_read_decode #(
    .DATA_W(DATA_W), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
  ) u_dec (
    .mode(mode_q), .off(off), .tbl_byte(tbl_byte), .data(dec_data), .use_array(dec_array)
  );

  assign rd_ready = !rsp_valid || rsp_ready;
  assign accept   = rd_valid && rd_ready;
  assign mode     = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_array <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= dec_data;
      rsp_array <= dec_array;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_array)));

  assert_read_mode_array_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_q == MODE_READ) |=> (rsp_valid && rsp_array && rsp_data == '0));
endmodule

// File: tb/sim_qry_responder.sv
module sim_qry_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        autosel_enter = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [19:0] rd_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        rsp_array;
  logic [1:0]  mode;

  int total = 0;
  int bad = 0;
  logic [1:0] mdl = 2'd0;

  always #2.5 clk = ~clk;

  qry_responder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .autosel_enter(autosel_enter), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_array(rsp_array),
    .mode(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_tbl(input int a);
    case (a)
      'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
      'h13: return 8'h02; 'h15: return 8'h40;
      'h21: return 8'h09; 'h22: return 8'h0C; 'h27: return 8'd20;
      'h2C: return 8'h02;
      'h2D: return 8'h07; 'h2F: return 8'h20;
      'h31: return 8'h0E; 'h34: return 8'h01;
      'h40: return 8'h50; 'h41: return 8'h52; 'h42: return 8'h49;
      'h43: return 8'h31; 'h44: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  // returns {array_flag, data}
  function automatic logic [16:0] exp_read(input logic [1:0] m, input logic [19:0] a);
    int o = int'(a[7:0]) >> 1;
    if (m == 2'd0) return {1'b1, 16'h0};
    if (m == 2'd1) begin
      case (o)
        0: return {1'b0, 16'h0001};
        1: return {1'b0, 16'h227E};
        2: return {1'b0, 16'h0000};
        'h0E: return {1'b0, 16'h2201};
        default: return {1'b1, 16'h0};
      endcase
    end
    return {1'b0, 8'h00, exp_tbl(o)};
  endfunction

  function automatic logic [1:0] next_mode(input logic [1:0] m, input logic [19:0] a, input logic [7:0] d);
    logic hit = ((a >> 1) & 20'h7FF) == 20'h055 && d == 8'h98;
    case (m)
      2'd0: return hit ? 2'd2 : 2'd0;
      2'd1: return hit ? 2'd3 : 2'd0;
      2'd2: return 2'd0;
      default: return (d == 8'hF0) ? 2'd1 : 2'd0;
    endcase
  endfunction

  task automatic do_write(input logic [19:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    mdl = next_mode(mdl, a, d);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(req, {30'd0, mode}, {30'd0, mdl});
  endtask

  task automatic do_pulse(input string req);
    @(negedge clk);
    autosel_enter = 1'b1;
    if (mdl == 2'd0) mdl = 2'd1;
    @(negedge clk);
    autosel_enter = 1'b0;
    chk(req, {30'd0, mode}, {30'd0, mdl});
  endtask

  task automatic do_read(input logic [19:0] a, input string req);
    logic [16:0] e;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    e = exp_read(mdl, a);
    @(negedge clk);
    rd_valid = 1'b0;
    chk({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk(req, {15'd0, rsp_array, rsp_data}, {15'd0, e});
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", {30'd0, mode}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 rd_ready", {31'd0, rd_ready}, 32'd1);

    do_read(20'h00010, "R11 read mode");
    do_write(20'h000AC, 8'h98, "R2 wrong addr");
    do_write(20'h000AB, 8'h98, "R2 entry odd byte");
    for (int i = 0; i < 128; i++) do_read(20'h30000 | 20'(i * 2), "R9 R10 table sweep");
    do_write(20'h000AA, 8'h98, "R5 any write exits");
    do_pulse("R6 pulse enters autoselect");
    do_read(20'h00000, "R7 id0");
    do_read(20'h00002, "R7 id1");
    do_read(20'h00004, "R7 prot");
    do_read(20'h0001C, "R8 id2");
    do_read(20'h0001E, "R8 id3 fallback");
    do_read(20'h00006, "R8 other offset");
    do_write(20'h000AA, 8'h98, "R3 query from autoselect");
    do_read(20'h00022, "R9 signature in mode 3");
    do_pulse("R6 pulse ignored in mode 3");
    do_write(20'h00000, 8'hF0, "R4 reset returns to autoselect");
    do_write(20'h00000, 8'hF0, "R6 reset leaves autoselect");
    do_pulse("R6 enter again");
    do_write(20'h000AA, 8'h98, "R3 again");
    do_write(20'h000AA, 8'h98, "R4 other write to read");

    // same-cycle write and pulse: write wins
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 20'h00010; wr_data = 8'h55; autosel_enter = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; autosel_enter = 1'b0;
    chk("R6 write beats pulse", {30'd0, mode}, 32'd0);

    // back-pressure
    do_write(20'h000AA, 8'h98, "R2 entry");
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_addr = 20'h00020;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R12 held ready low", {31'd0, rd_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 held valid", {31'd0, rsp_valid}, 32'd1);
    chk("R12 held data", {16'd0, rsp_data}, 32'h51);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", {31'd0, rsp_valid}, 32'd0);

    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 5));
      logic [19:0] a = 20'($urandom);
      logic [7:0]  d;
      case ($urandom_range(0, 3))
        0: d = 8'h98; 1: d = 8'hF0; 2: d = 8'h90; default: d = 8'($urandom);
      endcase
      if ($urandom_range(0, 1) == 1) a = {a[19:11], 11'h0AA} | 20'(a[0]);
      if (op == 0) do_write(a, d, "R2 R3 R4 R5 R6 random write");
      else if (op == 1) do_pulse("R6 random pulse");
      else do_read({12'h0, 8'($urandom_range(0, 255))}, "R7 R8 R9 R11 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule